// File: doc/BRIEF.md
# Token-Ring Cascaded FIFO

This block builds one deep first-in first-out buffer out of several identical storage slices. Each slice is a small circular buffer. The slices are wired in a ring through a two-bit hand-off link: each slice's link output drives the link input of the next slice, and the last slice drives the first. Write strobe, read strobe, write data, clock and reset go to every slice. Only one slice, the write-token holder, stores incoming words. Only one slice, the read-token holder, supplies read data.

When the write-token holder stores a word in its highest location, it raises the write-pass bit of its link output for that single cycle. At the same clock edge it drops the token, and the next slice picks it up. The read token moves round the ring the same way. Words therefore leave the buffer in the order they arrived, across slice boundaries, and the whole ring holds SLICES × SLICE_DEPTH words.

The operating mode is latched during reset. A slice with its first-load input low is the ring's starting slice. A slice that sees its link input held at zero while first-load is high runs alone, keeps both tokens for good and wraps inside itself. A top built with one slice is wired in this way.

Top module: `depth_ring_fifo`

## Requirements
- R1: While reset is held and in the first cycle after it, `empty` is 1, `full` is 0, `dout_valid` is 0 and `dout` is all zeros.
- R2: Words are returned in exactly the order they were accepted, including across every boundary between slices and across ring wrap-around.
- R3: Starting from empty, exactly SLICES × SLICE_DEPTH writes are accepted. `full` rises in the cycle after the clock edge that accepts the last of them, and it is 1 exactly when the stored count equals that capacity.
- R4: A write presented while `full` is 1 is dropped. It stores nothing and does not move any pointer, so the words read out afterwards are the same as if the write had never been presented.
- R5: A read presented while `empty` is 1 is dropped. `dout_valid` stays 0 in the next cycle and the stored count does not change.
- R6: A read accepted at a clock edge puts the oldest word on `dout`, with `dout_valid` = 1, for exactly the following cycle. Whenever `dout_valid` is 0, `dout` is all zeros.
- R7: Outside reset, exactly one slice holds the write token and exactly one slice holds the read token.
- R8: `empty` is 1 exactly when the count of accepted writes minus accepted reads is zero. `empty` is the AND of all the per-slice empty indications, and `full` is the AND of all the per-slice full indications.
- R9: A top built with SLICES = 1 has no ring connection. The slice runs alone, keeps both tokens and behaves as a SLICE_DEPTH-word buffer that meets R2 to R6.
- R10: A token moves only from a slice to the next slice in ring order (slice i to slice i+1, the last slice to slice 0). It moves only on the edge at which the holder writes (for the write token) or reads (for the read token) its location SLICE_DEPTH-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all slices |
| rst | input | 1 | Synchronous active-high reset; the mode of each slice is latched while it is high |
| wr_en | input | 1 | Write strobe; acted on only when `full` is 0 |
| din | input | WIDTH | Write data |
| rd_en | input | 1 | Read strobe; acted on only when `empty` is 0 |
| dout | output | WIDTH | Read data from the read-token slice; zero when not valid |
| dout_valid | output | 1 | High for the cycle after an accepted read |
| full | output | 1 | Composite full indication |
| empty | output | 1 | Composite empty indication |

## Verification
If a token is lost, duplicated or handed to the wrong slice, the ports show it within one slice's worth of traffic. When the read side moves to the wrong slice, the next read returns a stale or out-of-order word. When the write side moves to the wrong slice, `full` or `empty` no longer follows the accepted-transfer count, or a later read returns a word from the wrong slot. A per-slice pointer or counter that drifts shows up at the latest when that slice is next filled or drained. At that point the word sequence or the `full`/`empty` timing departs from a simple queue model.

// File: rtl/ring_fifo_pkg.sv
package ring_fifo_pkg;
  // Hand-off link between neighbouring slices; each bit is a one-cycle pass
  typedef struct packed {
    logic wr_pass;
    logic rd_pass;
  } xpand_t;
endpackage

// File: rtl/ring_slice_ram.sv
module ring_slice_ram #(
  parameter int WIDTH  = 9,
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WIDTH-1:0]  rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ring_slice.sv
module ring_slice
  import ring_fifo_pkg::*;
#(
  parameter int WIDTH = 9,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             first_load_n,
  input  xpand_t           xin,
  output xpand_t           xout,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] din,
  input  logic             rd_en,
  output logic [WIDTH-1:0] q_data,
  output logic             q_vld,
  output logic             slc_full,
  output logic             slc_empty,
  output logic             wtok_o,
  output logic             rtok_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic          alone_q, wtok_q, rtok_q;
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          wr_go, rd_go, wr_last, rd_last, link_seen;

  assign slc_full  = (cnt_q == CW'(DEPTH));
  assign slc_empty = (cnt_q == '0);
  assign wr_go     = wr_en & wtok_q & ~slc_full;
  assign rd_go     = rd_en & rtok_q & ~slc_empty;
  assign wr_last   = wr_go & (wptr_q == LAST);
  assign rd_last   = rd_go & (rptr_q == LAST);
  assign link_seen = xin.wr_pass | xin.rd_pass;
  assign wtok_o    = wtok_q;
  assign rtok_o    = rtok_q;

  // During reset every slice drives its link high, so a ring member sees
  // activity on its input while a slice wired alone sees a constant zero.
  always_comb begin
    if (rst) begin
      xout.wr_pass = 1'b1;
      xout.rd_pass = 1'b1;
    end else begin
      xout.wr_pass = wr_last & ~alone_q;
      xout.rd_pass = rd_last & ~alone_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      alone_q <= first_load_n & ~link_seen;
      wtok_q  <= ~first_load_n | ~link_seen;
      rtok_q  <= ~first_load_n | ~link_seen;
      wptr_q  <= '0;
      rptr_q  <= '0;
      cnt_q   <= '0;
      q_vld   <= 1'b0;
    end else begin
      if (!alone_q) begin
        wtok_q <= (wtok_q & ~wr_last) | xin.wr_pass;
        rtok_q <= (rtok_q & ~rd_last) | xin.rd_pass;
      end
      if (wr_go) wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + AW'(1);
      if (rd_go) rptr_q <= (rptr_q == LAST) ? '0 : rptr_q + AW'(1);
      cnt_q <= cnt_q + CW'(wr_go) - CW'(rd_go);
      q_vld <= rd_go;
    end
  end

  ring_slice_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH), .ADDR_W(AW)) ram_i (
    .clk  (clk),
    .we   (wr_go),
    .waddr(wptr_q),
    .wdata(din),
    .re   (rd_go),
    .raddr(rptr_q),
    .rdata(q_data)
  );
endmodule

// File: rtl/depth_ring_fifo.sv
module depth_ring_fifo
  import ring_fifo_pkg::*;
#(
  parameter int WIDTH       = 9,
  parameter int SLICE_DEPTH = 8,
  parameter int SLICES      = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] din,
  input  logic             rd_en,
  output logic [WIDTH-1:0] dout,
  output logic             dout_valid,
  output logic             full,
  output logic             empty
);
  xpand_t            xo [SLICES];
  xpand_t            xi [SLICES];
  logic [WIDTH-1:0]  qd [SLICES];
  logic [SLICES-1:0] vld_vec, full_vec, empty_vec, wtok_vec, rtok_vec;

  for (genvar i = 0; i < SLICES; i++) begin : g_slice
    if (SLICES == 1) begin : g_alone
      assign xi[i] = '0;
    end else begin : g_ring
      assign xi[i] = xo[(i + SLICES - 1) % SLICES];
    end

    ring_slice #(.WIDTH(WIDTH), .DEPTH(SLICE_DEPTH)) slice_i (
      .clk         (clk),
      .rst         (rst),
      .first_load_n((i == 0 && SLICES > 1) ? 1'b0 : 1'b1),
      .xin         (xi[i]),
      .xout        (xo[i]),
      .wr_en       (wr_en),
      .din         (din),
      .rd_en       (rd_en),
      .q_data      (qd[i]),
      .q_vld       (vld_vec[i]),
      .slc_full    (full_vec[i]),
      .slc_empty   (empty_vec[i]),
      .wtok_o      (wtok_vec[i]),
      .rtok_o      (rtok_vec[i])
    );
  end

  always_comb begin
    dout = '0;
    for (int k = 0; k < SLICES; k++) begin
      if (vld_vec[k]) dout = dout | qd[k];
    end
  end

  assign dout_valid = |vld_vec;
  assign full       = &full_vec;
  assign empty      = &empty_vec;
endmodule

// File: rtl/ring_fifo_chk.sv
module ring_fifo_chk #(
  parameter int WIDTH  = 9,
  parameter int SLICES = 4,
  parameter int TOTAL  = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             rd_en,
  input logic [WIDTH-1:0] dout,
  input logic             dout_valid,
  input logic             full,
  input logic             empty,
  input logic [SLICES-1:0] wtok,
  input logic [SLICES-1:0] rtok
);
  localparam int OW = $clog2(TOTAL + 1);

  logic [OW-1:0] occ_q;
  logic          armed_q;

  function automatic logic [SLICES-1:0] rotl(input logic [SLICES-1:0] v);
    logic [SLICES-1:0] r;
    for (int k = 0; k < SLICES; k++) r[(k + 1) % SLICES] = v[k];
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      occ_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      occ_q   <= occ_q + OW'(wr_en && !full) - OW'(rd_en && !empty);
      armed_q <= 1'b1;
    end
  end

  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (empty && !full && !dout_valid && dout == '0));

  a_r7_one_wtok: assert property (@(posedge clk) disable iff (rst)
    $countones(wtok) == 1);
  a_r7_one_rtok: assert property (@(posedge clk) disable iff (rst)
    $countones(rtok) == 1);

  a_r10_wtok_ring: assert property (@(posedge clk) disable iff (rst)
    (armed_q && wtok != $past(wtok)) |-> (wtok == rotl($past(wtok))));
  a_r10_rtok_ring: assert property (@(posedge clk) disable iff (rst)
    (armed_q && rtok != $past(rtok)) |-> (rtok == rotl($past(rtok))));

  a_r8_empty_tracks: assert property (@(posedge clk) disable iff (rst)
    empty == (occ_q == '0));
  a_r3_full_tracks: assert property (@(posedge clk) disable iff (rst)
    full == (occ_q == OW'(TOTAL)));

  a_r6_read_gives_word: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !empty) |=> dout_valid);
  a_r5_no_phantom_word: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && !empty) |=> !dout_valid);
  a_r6_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !dout_valid |-> (dout == '0));
endmodule

bind depth_ring_fifo ring_fifo_chk #(
  .WIDTH (WIDTH),
  .SLICES(SLICES),
  .TOTAL (SLICES * SLICE_DEPTH)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .dout      (dout),
  .dout_valid(dout_valid),
  .full      (full),
  .empty     (empty),
  .wtok      (wtok_vec),
  .rtok      (rtok_vec)
);

// File: tb/depth_ring_fifo_tb_top.sv
`timescale 1ns/1ps
module depth_ring_fifo_tb_top;
  localparam int W     = 9;
  localparam int SD    = 8;
  localparam int NS    = 4;
  localparam int CAP_M = SD * NS;
  localparam int CAP_S = SD;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0, rd_en = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout_m, dout_s;
  logic         vld_m, vld_s, full_m, full_s, empty_m, empty_s;

  int checks = 0;
  int fails  = 0;

  logic [W-1:0] q_m[$];
  logic [W-1:0] q_s[$];
  logic         exp_vld_m = 1'b0, exp_vld_s = 1'b0;
  logic [W-1:0] exp_dat_m = '0, exp_dat_s = '0;

  always #2.5 clk = ~clk;

  depth_ring_fifo #(.WIDTH(W), .SLICE_DEPTH(SD), .SLICES(NS)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .din(din), .rd_en(rd_en),
    .dout(dout_m), .dout_valid(vld_m), .full(full_m), .empty(empty_m)
  );

  depth_ring_fifo #(.WIDTH(W), .SLICE_DEPTH(SD), .SLICES(1)) dut_sa_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .din(din), .rd_en(rd_en),
    .dout(dout_s), .dout_valid(vld_s), .full(full_s), .empty(empty_s)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int exp_word(input logic v, input logic [W-1:0] d);
    return v ? int'(d) : 0;
  endfunction

  task automatic check_outputs(input string tag);
    // R7 R10: a token held by the wrong slice shows here as a wrong word or flag
    chk(tag,  "dout",       int'(dout_m), exp_word(exp_vld_m, exp_dat_m));
    chk("R6", "dout_valid", int'(vld_m),  int'(exp_vld_m));
    chk("R3", "full",       int'(full_m), int'(q_m.size() == CAP_M));
    chk("R8", "empty",      int'(empty_m), int'(q_m.size() == 0));
    chk("R9", "alone dout", int'(dout_s), exp_word(exp_vld_s, exp_dat_s));
    chk("R9", "alone valid", int'(vld_s), int'(exp_vld_s));
    chk("R9", "alone full", int'(full_s), int'(q_s.size() == CAP_S));
    chk("R9", "alone empty", int'(empty_s), int'(q_s.size() == 0));
  endtask

  // Check what the previous edge produced, then drive one cycle of stimulus
  task automatic step(input bit w, input bit r, input logic [W-1:0] d, input string tag);
    check_outputs(tag);
    wr_en = w;
    rd_en = r;
    din   = d;
    exp_vld_m = r && (q_m.size() > 0);
    if (exp_vld_m) exp_dat_m = q_m.pop_front();
    exp_vld_s = r && (q_s.size() > 0);
    if (exp_vld_s) exp_dat_s = q_s.pop_front();
    if (w && (q_m.size() + (exp_vld_m ? 1 : 0)) < CAP_M) q_m.push_back(d);
    if (w && (q_s.size() + (exp_vld_s ? 1 : 0)) < CAP_S) q_s.push_back(d);
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0123));
    repeat (4) @(negedge clk);
    // R1: state while reset is still applied
    chk("R1", "empty", int'(empty_m), 1);
    chk("R1", "full",  int'(full_m), 0);
    chk("R1", "dout_valid", int'(vld_m), 0);
    chk("R1", "dout",  int'(dout_m), 0);
    rst = 1'b0;

    // R5: reads on an empty buffer
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, '0, "R5");
    // R3: fill every slice, counting to exactly the capacity
    for (int i = 0; i < CAP_M; i++) step(1'b1, 1'b0, W'(i + 16), "R3");
    // R4: writes while full are dropped
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, W'(9'h1AA), "R4");
    // R2: drain across all slice boundaries, then extra reads when empty
    for (int i = 0; i < CAP_M + 3; i++) step(1'b0, 1'b1, '0, "R2");
    // Simultaneous read and write around the ring wrap
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, W'(i + 300), "R2");
    for (int i = 0; i < 3 * CAP_M; i++) step(1'b1, 1'b1, W'(i + 100), "R2");

    // Random phases with different write/read bias
    for (int ph = 0; ph < 6; ph++) begin
      int wp;
      int rp;
      wp = (ph % 3 == 0) ? 75 : (ph % 3 == 1) ? 30 : 50;
      rp = (ph % 3 == 0) ? 30 : (ph % 3 == 1) ? 75 : 50;
      for (int i = 0; i < 600; i++) begin
        step(($urandom % 100) < wp, ($urandom % 100) < rp, W'($urandom), "R2");
      end
    end
    for (int i = 0; i < CAP_M + 2; i++) step(1'b0, 1'b1, '0, "R2");
    check_outputs("R2");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule